// File: doc/BRIEF.md
# Dual-Law SPI Shift-Clock Divider

This block turns the fast module clock into the serial shift clock for an SPI shift engine. It does not gate any clock. It produces a registered clock level and two single-cycle strobes, one for each clock edge, and the shift engine uses these strobes as enables. A 13-bit setting holds two divisor fields and a select bit. The linear law divides the module clock by an even number between 2 and 512. The exponential law divides it by a power of two between 2 and 65536.

The shift engine raises `run` while it wants the clock. While `run` is low, the half-period counter stays at zero, the clock level stays low and no strobe appears. A new setting can be written at any time. It does not change the length of a half period that is already under way, so the shift clock never gets a shortened phase.

Top module: `spi_sclk_divider`

## Requirements
- R1: During reset and after it, `sclk` is low, both strobes are low and the internal setting is zero (exponential law, exponent 0).
- R2: When bit 12 of the setting is 1, the linear law applies: with n = bits 7:0, every half period lasts n+1 module cycles and the full `sclk` period lasts 2*(n+1) cycles.
- R3: When bit 12 is 0, the exponential law applies: with m = bits 11:8, every half period lasts 2^m module cycles and the full period lasts 2^(m+1) cycles.
- R4: The linear law with n=0 gives a strobe on every module cycle, so `sclk` runs at half the module clock.
- R5: If H is the half-period length and edge 1 is the first rising edge of `clk` at which `run` is sampled high, strobes occur at edges H, 2H, 3H and so on. At each strobe `sclk` toggles. The odd-numbered strobes are `lead_stb` (`sclk` goes 0 to 1) and the even-numbered ones are `trail_stb` (`sclk` goes 1 to 0). The two strobes are never high together.
- R6: After any edge at which `run` is sampled low, `sclk` and both strobes are low. A later run restarts counting from zero, even if the previous run ended partway through a half period.
- R7: A setting written while `run` is high takes effect only at the next half-period boundary. The half period in progress finishes at its old length.
- R8: A setting written while `run` is low is in force two cycles after the write, before the next run starts.
- R9: The divisor field of the law that is not selected has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the divider setting |
| cfg_wdata | input | 13 | Setting: [7:0] linear n, [11:8] exponent m, [12] law select (1 = linear) |
| run | input | 1 | Clock requested by the shift engine |
| sclk | output | 1 | Registered shift-clock level, low while idle |
| lead_stb | output | 1 | One-cycle strobe when `sclk` rises |
| trail_stb | output | 1 | One-cycle strobe when `sclk` falls |

## Verification
The assertions assume that `run` is held low throughout reset. They also assume that a setting only moves into force at a boundary or while idle, so the half-period limit never drops below a count that is already running. The stimulus drives every input at the falling clock edge and keeps `run` low during reset. It also holds `run` low for two cycles after each idle write, so that the new setting is in force before the next run begins. Mid-run writes are placed away from a boundary, so the cycle at which they take effect is unambiguous.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // law select encoding in the setting word
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;
endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int CFG_W = LIN_W + POW_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              apply,
  output logic [LIN_W-1:0]  lin_val,
  output logic [POW_W-1:0]  pow_val,
  output spi_div_pkg::div_law_e law
);
  logic [CFG_W-1:0] pending_q;
  logic [CFG_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
    end else if (wr_en) begin
      pending_q <= wr_data;
    end
  end

  // shadow copy moves in only at a half-period boundary or while idle
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (apply) begin
      active_q <= pending_q;
    end
  end

  assign lin_val = active_q[LIN_W-1:0];
  assign pow_val = active_q[LIN_W+POW_W-1:LIN_W];
  assign law     = spi_div_pkg::div_law_e'(active_q[CFG_W-1]);
endmodule

// File: rtl/spi_div_term.sv
module spi_div_term #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int POW_SPAN = (1 << POW_W) - 1,
  localparam int CNT_W = (POW_SPAN > LIN_W) ? POW_SPAN : LIN_W
) (
  input  logic [LIN_W-1:0]      lin_val,
  input  logic [POW_W-1:0]      pow_val,
  input  spi_div_pkg::div_law_e law,
  output logic [CNT_W-1:0]      term
);
  logic [CNT_W-1:0] lin_term;
  logic [CNT_W-1:0] pow_term;

  // half period minus one, for each law
  generate
    if (CNT_W > LIN_W) begin : g_lin_pad
      assign lin_term = {{(CNT_W-LIN_W){1'b0}}, lin_val};
    end else begin : g_lin_full
      assign lin_term = lin_val;
    end
  endgenerate

  always_comb begin
    pow_term = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (b < int'(pow_val)) pow_term[b] = 1'b1;
    end
  end

  assign term = (law == spi_div_pkg::LAW_LINEAR) ? lin_term : pow_term;
endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] term,
  output logic             boundary,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic [CNT_W-1:0] cnt_q;

  assign boundary = run && (cnt_q == term);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      sclk_o  <= 1'b0;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end else if (boundary) begin
      cnt_q   <= '0;
      sclk_o  <= ~sclk_o;
      lead_o  <= ~sclk_o;
      trail_o <= sclk_o;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      lead_o  <= 1'b0;
      trail_o <= 1'b0;
    end
  end

  // R6: idle request silences the outputs on the next edge
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sclk_o && !lead_o && !trail_o));

  // R5: never both edge strobes in one cycle
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lead_o, trail_o}));

  // R5: a lead strobe leaves the clock high, a trail strobe leaves it low
  p_lead_high_r5: assert property (@(posedge clk) disable iff (rst)
    lead_o |-> sclk_o);
  p_trail_low_r5: assert property (@(posedge clk) disable iff (rst)
    trail_o |-> !sclk_o);

  // R7: the running count never passes the limit in force (no short phase)
  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= term);
endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int CFG_W = LIN_W + POW_W + 1,
  localparam int POW_SPAN = (1 << POW_W) - 1,
  localparam int CNT_W = (POW_SPAN > LIN_W) ? POW_SPAN : LIN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             run,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  logic [LIN_W-1:0]      lin_val;
  logic [POW_W-1:0]      pow_val;
  spi_div_pkg::div_law_e law;
  logic [CNT_W-1:0]      term;
  logic                  boundary;

  spi_div_cfg #(.LIN_W(LIN_W), .POW_W(POW_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .apply   (boundary || !run),
    .lin_val (lin_val),
    .pow_val (pow_val),
    .law     (law)
  );

  spi_div_term #(.LIN_W(LIN_W), .POW_W(POW_W)) u_term (
    .lin_val (lin_val),
    .pow_val (pow_val),
    .law     (law),
    .term    (term)
  );

  spi_div_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .term     (term),
    .boundary (boundary),
    .sclk_o   (sclk),
    .lead_o   (lead_stb),
    .trail_o  (trail_stb)
  );

  // R7: mid-run the half-period limit changes only right after a boundary
  p_limit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$past(boundary)) |-> $stable(term));
endmodule

// File: tb/sim_spi_sclk_divider.sv
module sim_spi_sclk_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        run = 1'b0;
  logic        sclk, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string cur_tag = "R1";

  int    qc[$];
  bit    ql[$];
  string qt[$];

  always #5 clk = ~clk;

  spi_sclk_divider u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .run(run), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int half_of(logic [12:0] c);
    return c[12] ? int'(c[7:0]) + 1 : (1 << c[11:8]);
  endfunction

  // monitor: pop the expected strobe and compare cycle and kind
  always @(negedge clk) begin
    if (!rst && (lead_stb || trail_stb)) begin
      checks++;
      if (lead_stb && trail_stb) begin
        errors++;
        $display("FAIL R5: both strobes high at edge %0d (expected one)", cyc);
      end else if (qc.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected strobe lead=%0b at edge %0d (expected none)",
                 cur_tag, lead_stb, cyc);
      end else begin
        int c; bit l; string t;
        c = qc.pop_front(); l = ql.pop_front(); t = qt.pop_front();
        if (c != cyc || l != lead_stb) begin
          errors++;
          $display("FAIL %s: strobe at edge %0d lead=%0b (expected edge %0d lead=%0b)",
                   t, cyc, lead_stb, c, l);
        end
      end
    end
  end

  task automatic check_idle(string tag);
    checks++;
    if (sclk || lead_stb || trail_stb) begin
      errors++;
      $display("FAIL %s: idle outputs sclk=%0b lead=%0b trail=%0b (expected 0 0 0)",
               tag, sclk, lead_stb, trail_stb);
    end
  endtask

  task automatic write_idle(logic [12:0] c);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // driver: push expected strobes, run, then release and check idle
  task automatic run_seq(logic [12:0] c, int n, string tag);
    int h, c0, last;
    cur_tag = tag;
    write_idle(c);
    h = half_of(c);
    c0 = cyc + 1;
    for (int j = 1; j <= n; j++) begin
      qc.push_back(c0 + j*h - 1); ql.push_back(j % 2 == 1); qt.push_back(tag);
    end
    last = c0 + n*h - 1;
    run = 1'b1;
    while (cyc != last) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_idle("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");

    // R4: linear n=0, strobe every cycle
    run_seq(13'h1000, 8, "R4");
    // R2: linear laws
    run_seq(13'h1002, 4, "R2");
    run_seq(13'h10FF, 4, "R2");
    // R3: exponential laws
    run_seq(13'h0000, 6, "R3");
    run_seq(13'h0300, 4, "R3");
    run_seq(13'h0C00, 2, "R3");
    // R9: unselected field ignored in each law
    run_seq(13'h1701, 4, "R9");
    run_seq(13'h03AB, 4, "R9");

    // R6: abort midway through a half period, then restart from zero
    cur_tag = "R6";
    write_idle(13'h0300);
    run = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check_idle("R6");
    run_seq(13'h0300, 2, "R6");

    // R7: change linear n=2 to n=0 while running, write sampled at edge 4
    begin
      int c0;
      int ks[6] = '{3, 6, 7, 8, 9, 10};
      cur_tag = "R7";
      write_idle(13'h1002);
      c0 = cyc + 1;
      for (int j = 0; j < 6; j++) begin
        qc.push_back(c0 + ks[j] - 1); ql.push_back(j % 2 == 0); qt.push_back("R7");
      end
      run = 1'b1;
      while (cyc != c0 + 2) @(negedge clk);
      cfg_wr = 1'b1; cfg_wdata = 13'h1000;
      @(negedge clk);
      cfg_wr = 1'b0;
      while (cyc != c0 + 9) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_idle("R7");
    end

    // R8: idle write in force before the next run (exp m=1 after linear n=0)
    run_seq(13'h0100, 4, "R8");

    checks++;
    if (qc.size() != 0) begin
      errors++;
      $display("FAIL R5: %0d expected strobes missing (expected 0)", qc.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end (expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule